// File: doc/BRIEF.md
# Conflict Address Buffer

This block sits next to a signature-based eager conflict detector inside one core of a transactional-memory system. Hashed read and write signatures can report a conflict for an address that the local transaction never touched. The buffer records the exact cache-block addresses that have already produced a signature conflict. For each one it keeps a conservative note of whether the running transaction may have read or written that block. When a request from another core targets a recorded block, and the notes show that no real conflict can exist, the buffer raises a mask. The mask turns the signature's NACK into an acknowledge.

The block has a small, fully associative set of entries. Each entry holds a block address, a valid flag, a may-read flag and a may-write flag. An entry is allocated when a remote request has a signature conflict and misses every stored address. The allocation copies the signature bits for that address. Local reads and writes that hit an entry set its flags. Ending a transaction, by commit or by abort, clears the flags and keeps the addresses. Starting a thread or switching threads empties the whole buffer. When all entries are valid, the least recently used one is replaced.

Top module: `conflict_addr_buf`

## Requirements
- R1: After reset, and in the cycle after a thread-start or thread-switch pulse, every entry is invalid. A remote request to any address then gives `nack_mask`=0.
- R2: A remote request with `sig_conflict`=0 never allocates an entry. A later request to the same block therefore still misses (`nack_mask`=0).
- R3: On allocation, the entry's read and write flags take the values of `sig_rd_bit` and `sig_wr_bit` from the allocating request.
- R4: A local read (`loc_write`=0) that hits a valid entry sets its read flag. A remote write to that block is then not masked, and a remote read is still masked.
- R5: A local write (`loc_write`=1) that hits a valid entry sets its write flag. A remote read to that block is then not masked.
- R6: A remote read (`rem_write`=0) that hits an entry with its write flag clear asserts `nack_mask`. A remote write (`rem_write`=1) asserts it only when both flags are clear. A miss never asserts it.
- R7: `nack_out` is 1 exactly when `rem_valid` and `sig_conflict` are 1 and `nack_mask` is 0. Both outputs are combinational in the request cycle.
- R8: A request that allocates an entry is not masked in its allocating cycle.
- R9: A commit or abort pulse clears the read and write flags of every entry and keeps every valid flag.
- R10: While any entry is invalid, allocation fills an invalid entry, so that filling ENTRIES distinct blocks keeps all of them resident.
- R11: With every entry valid, allocation replaces the least recently used entry. An entry counts as used when it is allocated, when a local access hits it, and when a remote request it masks hits it.
- R12: A local access and a remote request in the same cycle are applied local first. A local write to block X suppresses the mask for a remote read of X in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_start | input | 1 | Pulse: a new thread begins; empties the buffer |
| thr_switch | input | 1 | Pulse: thread switch; empties the buffer |
| tx_commit | input | 1 | Pulse: transaction commit; clears the access flags |
| tx_abort | input | 1 | Pulse: transaction abort; clears the access flags |
| loc_valid | input | 1 | Local transactional access present |
| loc_write | input | 1 | Local access is a write (1) or a read (0) |
| loc_blk | input | BLK_W | Cache-block address of the local access |
| rem_valid | input | 1 | Remote transactional request present |
| rem_write | input | 1 | Remote request is a write (1) or a read (0) |
| rem_blk | input | BLK_W | Cache-block address of the remote request |
| sig_conflict | input | 1 | Signature detector reports a conflict for the remote request |
| sig_rd_bit | input | 1 | Read-signature bit for the remote address |
| sig_wr_bit | input | 1 | Write-signature bit for the remote address |
| nack_mask | output | 1 | The buffer proves the conflict false; suppress the NACK |
| nack_out | output | 1 | Final NACK after masking |

## Verification
The bench builds the buffer with its defaults: four entries and a 26-bit block address. With four entries the buffer can be filled completely in a few cycles. An eviction is reached after a handful of requests, and the victim can be steered by touching entries in a chosen order. The narrow entry count lets one scenario hold every entry valid, re-touch them, and confirm which one is evicted by probing with non-conflicting requests. The flag scenarios cover each combination of request type and stored flags, including a local write and a remote read to the same block in the same cycle.

// File: rtl/cab_pkg.sv
// Shared types and the mask decision for the conflict address buffer.
// Assumes: request kind is encoded as a single bit (0 read, 1 write).
package cab_pkg;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_e;

    // True when a hit with these flags proves the remote access conflict-free.
    function automatic logic proves_no_conflict(acc_e kind, logic may_rd, logic may_wr);
        return !may_wr && ((kind == ACC_READ) || !may_rd);
    endfunction

endpackage

// File: rtl/cab_match.sv
// Fully associative comparator: compares a key against every stored tag.
// Assumes: at most one valid entry holds a given tag (allocation only on miss).
module cab_match #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 26,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input  logic [ENTRIES-1:0]            valid,
    input  logic [TAG_W-1:0]              key,
    output logic [ENTRIES-1:0]            hit_vec,
    output logic                          hit,
    output logic [IDX_W-1:0]              hit_idx
);

    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == key);
    end

    assign hit = |hit_vec;

    // Encode the (single) matching entry as an index.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/cab_lru.sv
// Least-recently-used tracker using one rank per entry (0 = most recent).
// Up to two touches per cycle, applied port A first, then port B.
// Assumes: ranks form a permutation of 0..ENTRIES-1, restored on clear.
module cab_lru #(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               ta_en,
    input  logic [IDX_W-1:0]   ta_idx,
    input  logic               tb_en,
    input  logic [IDX_W-1:0]   tb_idx,
    output logic [ENTRIES-1:0] oldest_vec
);

    logic [IDX_W-1:0] rank_q   [ENTRIES];
    logic [IDX_W-1:0] rank_mid [ENTRIES];
    logic [IDX_W-1:0] rank_nxt [ENTRIES];

    // Apply touch A, then touch B, each moving its entry to rank 0.
    always_comb begin
        rank_mid = rank_q;
        if (ta_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (rank_q[i] < rank_q[ta_idx]) rank_mid[i] = rank_q[i] + 1'b1;
            end
            rank_mid[ta_idx] = '0;
        end
        rank_nxt = rank_mid;
        if (tb_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (rank_mid[i] < rank_mid[tb_idx]) rank_nxt[i] = rank_mid[i] + 1'b1;
            end
            rank_nxt[tb_idx] = '0;
        end
    end

    // Rank registers; reset and clear restore the identity order.
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n || clear) rank_q[i] <= IDX_W'(i);
            else                 rank_q[i] <= rank_nxt[i];
        end
    end

    // Flag the entry holding the oldest rank.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_old
        assign oldest_vec[g] = (rank_q[g] == IDX_W'(ENTRIES - 1));
    end

endmodule

// File: rtl/conflict_addr_buf.sv
// Conflict address buffer. Records block addresses that produced a signature
// conflict and masks the NACK of remote requests it can prove conflict-free.
// Assumes: block addresses arrive already stripped of the in-block offset;
// clear events (thread start/switch) take priority over all other updates;
// commit/abort clears the access flags, including flags of an entry
// allocated in the same cycle.
module conflict_addr_buf #(
    parameter int ENTRIES = 4,
    parameter int BLK_W   = 26,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_start,
    input  logic             thr_switch,
    input  logic             tx_commit,
    input  logic             tx_abort,
    input  logic             loc_valid,
    input  logic             loc_write,
    input  logic [BLK_W-1:0] loc_blk,
    input  logic             rem_valid,
    input  logic             rem_write,
    input  logic [BLK_W-1:0] rem_blk,
    input  logic             sig_conflict,
    input  logic             sig_rd_bit,
    input  logic             sig_wr_bit,
    output logic             nack_mask,
    output logic             nack_out
);
    import cab_pkg::*;

    logic [ENTRIES-1:0][BLK_W-1:0] tag_q;
    logic [ENTRIES-1:0]            v_q, r_q, w_q;

    logic [ENTRIES-1:0] loc_hit_vec, rem_hit_vec;
    logic               loc_hit, rem_hit;
    logic [IDX_W-1:0]   loc_idx, rem_idx;

    logic               thr_clr, tx_end;
    logic [ENTRIES-1:0] loc_set_r, loc_set_w, eff_r, eff_w;
    logic               hit_r, hit_w;
    logic               alloc_en;
    logic [ENTRIES-1:0] lru_old;
    logic [IDX_W-1:0]   victim_idx, free_idx, old_idx;

    assign thr_clr = thr_start | thr_switch;
    assign tx_end  = tx_commit | tx_abort;

    cab_match #(.ENTRIES(ENTRIES), .TAG_W(BLK_W)) u_loc_match (
        .tags(tag_q), .valid(v_q), .key(loc_blk),
        .hit_vec(loc_hit_vec), .hit(loc_hit), .hit_idx(loc_idx)
    );

    cab_match #(.ENTRIES(ENTRIES), .TAG_W(BLK_W)) u_rem_match (
        .tags(tag_q), .valid(v_q), .key(rem_blk),
        .hit_vec(rem_hit_vec), .hit(rem_hit), .hit_idx(rem_idx)
    );

    // Local access flags, forwarded so the remote decision sees them this cycle.
    always_comb begin
        loc_set_r = (loc_valid && !loc_write) ? loc_hit_vec : '0;
        loc_set_w = (loc_valid &&  loc_write) ? loc_hit_vec : '0;
        eff_r     = r_q | loc_set_r;
        eff_w     = w_q | loc_set_w;
        hit_r     = |(rem_hit_vec & eff_r);
        hit_w     = |(rem_hit_vec & eff_w);
    end

    // Mask decision from request kind and the hit entry's effective flags.
    assign nack_mask = rem_valid && rem_hit &&
                       proves_no_conflict(acc_e'(rem_write), hit_r, hit_w);
    assign nack_out  = rem_valid && sig_conflict && !nack_mask;

    // Allocate only on a signature conflict that misses the buffer.
    assign alloc_en = rem_valid && sig_conflict && !rem_hit && !thr_clr;

    // Victim choice: lowest invalid entry, else the least recently used one.
    always_comb begin
        free_idx = '0;
        old_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!v_q[i]) free_idx = IDX_W'(i);
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (lru_old[i]) old_idx = IDX_W'(i);
        end
        victim_idx = (&v_q) ? old_idx : free_idx;
    end

    cab_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk(clk), .rst_n(rst_n), .clear(thr_clr),
        .ta_en(loc_valid && loc_hit), .ta_idx(loc_idx),
        .tb_en(alloc_en || nack_mask), .tb_idx(alloc_en ? victim_idx : rem_idx),
        .oldest_vec(lru_old)
    );

    // Entry state: clear events, flag updates and allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
            v_q   <= '0;
            r_q   <= '0;
            w_q   <= '0;
        end else if (thr_clr) begin
            v_q <= '0;
            r_q <= '0;
            w_q <= '0;
        end else begin
            r_q <= tx_end ? '0 : eff_r;
            w_q <= tx_end ? '0 : eff_w;
            if (alloc_en) begin
                tag_q[victim_idx] <= rem_blk;
                v_q[victim_idx]   <= 1'b1;
                r_q[victim_idx]   <= sig_rd_bit && !tx_end;
                w_q[victim_idx]   <= sig_wr_bit && !tx_end;
            end
        end
    end

endmodule

// File: rtl/cab_checker.sv
// Property checker for the conflict address buffer, bound to its top module.
// Assumes: all properties are disabled while rst_n is low.
module cab_checker #(
    parameter int ENTRIES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               thr_start,
    input logic               thr_switch,
    input logic               tx_commit,
    input logic               tx_abort,
    input logic               rem_valid,
    input logic               sig_conflict,
    input logic               rem_hit,
    input logic               alloc_en,
    input logic               nack_mask,
    input logic [ENTRIES-1:0] v_q,
    input logic [ENTRIES-1:0] r_q,
    input logic [ENTRIES-1:0] w_q,
    input logic [ENTRIES-1:0] lru_old
);

    a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_start || thr_switch) |=> (v_q == '0 && r_q == '0 && w_q == '0));

    a_r2_alloc_needs_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        ((v_q & ~$past(v_q)) != '0) |-> $past(rem_valid && sig_conflict && !rem_hit));

    a_r6_mask_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        nack_mask |-> (rem_valid && rem_hit));

    a_r8_no_mask_on_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !nack_mask);

    a_r9_tx_end_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_commit || tx_abort) && !thr_start && !thr_switch) |=>
        ((r_q | w_q) == '0 && (v_q & $past(v_q)) == $past(v_q)));

    a_r11_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lru_old) == 1);

endmodule

bind conflict_addr_buf cab_checker #(.ENTRIES(ENTRIES)) u_cab_checker (
    .clk(clk), .rst_n(rst_n),
    .thr_start(thr_start), .thr_switch(thr_switch),
    .tx_commit(tx_commit), .tx_abort(tx_abort),
    .rem_valid(rem_valid), .sig_conflict(sig_conflict),
    .rem_hit(rem_hit), .alloc_en(alloc_en), .nack_mask(nack_mask),
    .v_q(v_q), .r_q(r_q), .w_q(w_q), .lru_old(lru_old)
);

// File: tb/test_conflict_addr_buf.sv
// Directed bench: one task per scenario, each checking its own results.
module test_conflict_addr_buf;
    localparam int ENTRIES = 4;
    localparam int BLK_W   = 26;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             thr_start, thr_switch, tx_commit, tx_abort;
    logic             loc_valid, loc_write;
    logic [BLK_W-1:0] loc_blk;
    logic             rem_valid, rem_write;
    logic [BLK_W-1:0] rem_blk;
    logic             sig_conflict, sig_rd_bit, sig_wr_bit;
    logic             nack_mask, nack_out;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    conflict_addr_buf #(.ENTRIES(ENTRIES), .BLK_W(BLK_W)) i_conflict_addr_buf (
        .clk(clk), .rst_n(rst_n),
        .thr_start(thr_start), .thr_switch(thr_switch),
        .tx_commit(tx_commit), .tx_abort(tx_abort),
        .loc_valid(loc_valid), .loc_write(loc_write), .loc_blk(loc_blk),
        .rem_valid(rem_valid), .rem_write(rem_write), .rem_blk(rem_blk),
        .sig_conflict(sig_conflict), .sig_rd_bit(sig_rd_bit), .sig_wr_bit(sig_wr_bit),
        .nack_mask(nack_mask), .nack_out(nack_out)
    );

    localparam logic [BLK_W-1:0] BA = 26'h0000_0A1;
    localparam logic [BLK_W-1:0] BB = 26'h0000_0B2;
    localparam logic [BLK_W-1:0] BC = 26'h0000_0C3;
    localparam logic [BLK_W-1:0] BD = 26'h0000_0D4;

    task automatic check(input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        thr_start = 0; thr_switch = 0; tx_commit = 0; tx_abort = 0;
        loc_valid = 0; loc_write = 0; loc_blk = '0;
        rem_valid = 0; rem_write = 0; rem_blk = '0;
        sig_conflict = 0; sig_rd_bit = 0; sig_wr_bit = 0;
    endtask

    // One remote request for one cycle; checks mask and final NACK (R7).
    task automatic remote(input logic [BLK_W-1:0] b, input logic wr, input logic conf,
                          input logic srd, input logic swr, input logic exp_mask,
                          input string what);
        @(negedge clk);
        rem_valid = 1; rem_write = wr; rem_blk = b;
        sig_conflict = conf; sig_rd_bit = srd; sig_wr_bit = swr;
        #1;
        check(nack_mask, exp_mask, {what, " mask"});
        check(nack_out, conf && !exp_mask, {what, " R7 nack"});
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic local_acc(input logic [BLK_W-1:0] b, input logic wr);
        @(negedge clk);
        loc_valid = 1; loc_write = wr; loc_blk = b;
        @(posedge clk); #1;
        idle_inputs();
    endtask

    // kind: 0 commit, 1 abort, 2 thread start, 3 thread switch
    task automatic pulse(input int kind);
        @(negedge clk);
        case (kind)
            0: tx_commit = 1;
            1: tx_abort = 1;
            2: thr_start = 1;
            default: thr_switch = 1;
        endcase
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic t_reset_state();
        remote(BA, 0, 0, 0, 0, 0, "R1 empty after reset read");
        remote(BA, 1, 0, 0, 0, 0, "R1 empty after reset write");
    endtask

    task automatic t_alloc_and_mask();
        remote(BA, 0, 1, 0, 0, 0, "R8 allocating read not masked");
        remote(BA, 0, 1, 0, 0, 1, "R6 read hit clean flags");
        remote(BA, 1, 1, 0, 0, 1, "R6 write hit clean flags");
        remote(BA + 1, 0, 0, 0, 0, 0, "R6 miss on neighbour block");
    endtask

    task automatic t_no_alloc();
        remote(BB, 0, 0, 0, 0, 0, "R2 no conflict first");
        remote(BB, 0, 0, 0, 0, 0, "R2 still a miss");
    endtask

    task automatic t_sig_copy();
        remote(BC, 0, 1, 1, 0, 0, "R3 alloc with read bit");
        remote(BC, 0, 1, 0, 0, 1, "R3 read flag copied, read masked");
        remote(BC, 1, 1, 0, 0, 0, "R3 read flag copied, write kept");
        remote(BD, 0, 1, 0, 1, 0, "R3 alloc with write bit");
        remote(BD, 0, 1, 0, 0, 0, "R3 write flag copied, read kept");
    endtask

    task automatic t_local_track();
        local_acc(BA, 0);
        remote(BA, 1, 1, 0, 0, 0, "R4 local read blocks write mask");
        remote(BA, 0, 1, 0, 0, 1, "R4 local read keeps read mask");
        local_acc(BA, 1);
        remote(BA, 0, 1, 0, 0, 0, "R5 local write blocks read mask");
    endtask

    task automatic t_tx_end();
        pulse(0);
        remote(BA, 0, 1, 0, 0, 1, "R9 commit clears A read");
        remote(BA, 1, 1, 0, 0, 1, "R9 commit clears A write");
        remote(BC, 1, 1, 0, 0, 1, "R9 commit clears C");
        remote(BD, 0, 1, 0, 0, 1, "R9 commit clears D, valid kept");
        local_acc(BC, 1);
        remote(BC, 0, 1, 0, 0, 0, "R5 local write on C");
        pulse(1);
        remote(BC, 0, 1, 0, 0, 1, "R9 abort clears C");
    endtask

    task automatic t_forward();
        @(negedge clk);
        loc_valid = 1; loc_write = 1; loc_blk = BA;
        rem_valid = 1; rem_write = 0; rem_blk = BA;
        sig_conflict = 1;
        #1;
        check(nack_mask, 1'b0, "R12 same-cycle local write suppresses mask");
        check(nack_out, 1'b1, "R12 same-cycle nack stands");
        @(posedge clk); #1;
        idle_inputs();
        remote(BA, 0, 1, 0, 0, 0, "R12 write flag kept after cycle");
        pulse(0);
    endtask

    task automatic t_lru();
        pulse(2);
        remote(BA, 0, 0, 0, 0, 0, "R1 thread start empties");
        for (int i = 0; i < 4; i++)
            remote(26'h1000 * (i + 1), 0, 1, 0, 0, 0, "R10 fill allocate");
        for (int i = 0; i < 4; i++)
            remote(26'h1000 * (i + 1), 0, 0, 0, 0, 1, "R10 all fills resident");
        local_acc(26'h1000, 0);   // touch E0: LRU becomes E1
        remote(26'h5000, 0, 1, 0, 0, 0, "R11 allocate into full buffer");
        remote(26'h2000, 0, 0, 0, 0, 0, "R11 LRU entry evicted");
        remote(26'h1000, 0, 0, 0, 0, 1, "R11 touched entry kept");
        remote(26'h3000, 0, 0, 0, 0, 1, "R11 entry 2 kept");
        remote(26'h4000, 0, 0, 0, 0, 1, "R11 entry 3 kept");
        remote(26'h5000, 0, 0, 0, 0, 1, "R11 new entry resident");
    endtask

    task automatic t_thread_switch();
        pulse(3);
        remote(26'h1000, 0, 0, 0, 0, 0, "R1 thread switch empties E0");
        remote(26'h5000, 0, 0, 0, 0, 0, "R1 thread switch empties E4");
    endtask

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset_state();
        t_alloc_and_mask();
        t_no_alloc();
        t_sig_copy();
        t_local_track();
        t_tx_end();
        t_forward();
        t_lru();
        t_thread_switch();
        repeat (2) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule